// File: doc/BRIEF.md
# Two-Stage Timebase Watchdog

This block is a watchdog timer built around a free-running timebase counter. Software controls it through three 32-bit words: two control/status words and a read-only view of the counter. Arming takes two enable bits that sit in two different words, so a single stray write cannot start or stop the timer. The expiry period is 2^N clock cycles, and N is fixed when the block is built.

Expiry happens in two stages. The first overflow of the timebase while the block is armed sets a watchdog-state flag, and that flag drives the interrupt output. If software does not service the block before the next overflow, the block sends a one-cycle pulse on its system-reset output and latches a reset-status flag. Software services the watchdog by writing ones to the status flags. That write clears the flags and restarts the timebase from zero, so a full period follows every service.

A build option can lock the enables. Once the block is armed, software can then no longer disarm it.

Top module: `tbase_wdog`

## Requirements
- R1: After reset, all three words read zero and both `irq` and `sys_rst` are low.
- R2: The timebase word (word index 2, byte offset 0x8) increases by one every clock unless a service write restarts it. Writes to that word have no effect.
- R3: Enable 1 is bit 1 of word 0 (offset 0x0). Enable 2 is bit 0 of word 1 (offset 0x4). Expiry, the interrupt and the reset pulse all need both enables set. While either enable is clear, no reset pulse occurs.
- R4: With both enables set, an overflow is a clock edge at which the low N bits of the timebase are all ones. The first such overflow sets the watchdog-state flag (bit 2 of word 0). `irq` is high exactly while that flag and both enables are set.
- R5: An overflow that occurs while the watchdog-state flag is already set drives `sys_rst` high for exactly one cycle. It also sets the reset-status flag (bit 3 of word 0), which stays set until it is cleared.
- R6: A write to word 0 with a one in bit 2 or bit 3 clears each flag written with one and restarts the timebase at zero. If such a write falls on an overflow edge, the service wins: no flag is set and no reset pulse follows.
- R7: Writing zero to bit 2 or bit 3 of word 0 leaves that flag unchanged.
- R8: With `ONCE_ONLY`=1, once both enables are set, writes cannot clear either of them. With `ONCE_ONLY`=0, writing zero to an enable bit clears it.
- R9: Unused bits of words 0 and 1 read zero, and any byte offset of 0xC or above reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| addr | input | ADDR_W | Byte address of the accessed word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | First-stage expiry interrupt, level |
| sys_rst | output | 1 | Second-stage expiry reset pulse |

## Verification
A wrong count value shows in the timebase word on the very next read. It then moves the overflow edge, so the flag, the interrupt and the reset pulse appear at a different cycle, within one period of 2^N cycles. A flag stuck or lost is visible in word 0 and on `irq` in the cycle after the edge that should have changed it. A reset pulse that is missing, duplicated or too long shows on `sys_rst` within one period after the second overflow. A broken lock shows in the enable bits on the first read after a disarm attempt.

// File: rtl/tbase_wdog_pkg.sv
package tbase_wdog_pkg;
   localparam int unsigned DATA_W    = 32;
   // word indices (byte offset / 4)
   localparam int unsigned WIDX_CS0  = 0;
   localparam int unsigned WIDX_CS1  = 1;
   localparam int unsigned WIDX_TB   = 2;
   // bit positions within the control/status words
   localparam int unsigned BIT_RST   = 3;
   localparam int unsigned BIT_STATE = 2;
   localparam int unsigned BIT_EN1   = 1;
   localparam int unsigned BIT_EN2   = 0;

   typedef struct packed {
      logic rst_flag;
      logic state_flag;
      logic en1;
      logic en2;
   } wd_flags_t;
endpackage

// File: rtl/tbase_wdog_count.sv
module tbase_wdog_count #(
   parameter int unsigned CNT_W      = 32,
   parameter int unsigned PERIOD_EXP = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   output logic [CNT_W-1:0] count,
   output logic             wrap
);
   localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       count <= '0;
      else if (restart) count <= '0;
      else              count <= count + STEP;
   end

   // low PERIOD_EXP bits all ones: the next edge rolls them over
   assign wrap = &count[PERIOD_EXP-1:0];
endmodule

// File: rtl/tbase_wdog_expiry.sv
module tbase_wdog_expiry (
   input  logic clk,
   input  logic rst_n,
   input  logic wrap,
   input  logic armed,
   input  logic keep,
   input  logic clr_state,
   input  logic clr_rst,
   output logic state_flag,
   output logic rst_flag,
   output logic rst_pulse
);
   logic fire;
   // service on the same edge beats the overflow
   assign fire = wrap & armed & ~keep;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_flag <= 1'b0;
         rst_flag   <= 1'b0;
         rst_pulse  <= 1'b0;
      end else begin
         if (clr_state)  state_flag <= 1'b0;
         else if (fire)  state_flag <= 1'b1;

         if (clr_rst)                 rst_flag <= 1'b0;
         else if (fire & state_flag)  rst_flag <= 1'b1;

         rst_pulse <= fire & state_flag;
      end
   end
endmodule

// File: rtl/tbase_wdog_regs.sv
module tbase_wdog_regs
   import tbase_wdog_pkg::*;
#(
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned CNT_W     = 32,
   parameter bit          ONCE_ONLY = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              state_flag,
   input  logic              rst_flag,
   input  logic [CNT_W-1:0]  count,
   output logic              en1,
   output logic              en2,
   output logic              keep,
   output logic              clr_state,
   output logic              clr_rst,
   output logic [DATA_W-1:0] rdata
);
   localparam int unsigned IDX_W = ADDR_W - 2;

   logic [IDX_W-1:0] word;
   logic             wr_cs0, wr_cs1, lock;
   wd_flags_t        flags;
   logic             unused_bits;

   assign word   = addr[ADDR_W-1:2];
   assign wr_cs0 = wr_en && (word == IDX_W'(WIDX_CS0));
   assign wr_cs1 = wr_en && (word == IDX_W'(WIDX_CS1));

   assign clr_state = wr_cs0 & wdata[BIT_STATE];
   assign clr_rst   = wr_cs0 & wdata[BIT_RST];
   assign keep      = clr_state | clr_rst;

   generate
      if (ONCE_ONLY) begin : g_lock
         assign lock = en1 & en2;
      end else begin : g_free
         assign lock = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en1 <= 1'b0;
         en2 <= 1'b0;
      end else begin
         if (wr_cs0) en1 <= wdata[BIT_EN1] | lock;
         if (wr_cs1) en2 <= wdata[BIT_EN2] | lock;
      end
   end

   assign flags = '{rst_flag: rst_flag, state_flag: state_flag, en1: en1, en2: en2};

   always_comb begin
      rdata = '0;
      if (word == IDX_W'(WIDX_CS0)) begin
         rdata[BIT_RST]   = flags.rst_flag;
         rdata[BIT_STATE] = flags.state_flag;
         rdata[BIT_EN1]   = flags.en1;
      end else if (word == IDX_W'(WIDX_CS1)) begin
         rdata[BIT_EN2]   = flags.en2;
      end else if (word == IDX_W'(WIDX_TB)) begin
         rdata[CNT_W-1:0] = count;
      end
   end

   assign unused_bits = ^{addr[1:0], wdata[DATA_W-1:4], flags.en2};
endmodule

// File: rtl/tbase_wdog.sv
module tbase_wdog
   import tbase_wdog_pkg::*;
#(
   parameter int unsigned PERIOD_EXP = 16,
   parameter int unsigned ADDR_W     = 4,
   parameter bit          ONCE_ONLY  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   output logic              irq,
   output logic              sys_rst
);
   localparam int unsigned CNT_W = DATA_W;

   generate
      if (PERIOD_EXP < 1 || PERIOD_EXP >= CNT_W) begin : g_bad_exp
         $error("tbase_wdog: PERIOD_EXP must lie in 1..%0d", CNT_W - 1);
      end
      if (ADDR_W < 4) begin : g_bad_addr
         $error("tbase_wdog: ADDR_W must be at least 4");
      end
   endgenerate

   logic [CNT_W-1:0] tb_count;
   logic             wrap, keep, clr_state, clr_rst;
   logic             en1, en2, state_flag, rst_flag;

   tbase_wdog_regs #(
      .ADDR_W   (ADDR_W),
      .CNT_W    (CNT_W),
      .ONCE_ONLY(ONCE_ONLY)
   ) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .addr      (addr),
      .wdata     (wdata),
      .state_flag(state_flag),
      .rst_flag  (rst_flag),
      .count     (tb_count),
      .en1       (en1),
      .en2       (en2),
      .keep      (keep),
      .clr_state (clr_state),
      .clr_rst   (clr_rst),
      .rdata     (rdata)
   );

   tbase_wdog_count #(
      .CNT_W     (CNT_W),
      .PERIOD_EXP(PERIOD_EXP)
   ) count_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .restart(keep),
      .count  (tb_count),
      .wrap   (wrap)
   );

   tbase_wdog_expiry expiry_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wrap      (wrap),
      .armed     (en1 & en2),
      .keep      (keep),
      .clr_state (clr_state),
      .clr_rst   (clr_rst),
      .state_flag(state_flag),
      .rst_flag  (rst_flag),
      .rst_pulse (sys_rst)
   );

   assign irq = state_flag & en1 & en2;
endmodule

// File: rtl/tbase_wdog_chk.sv
module tbase_wdog_chk #(
   parameter int unsigned ADDR_W    = 4,
   parameter bit          ONCE_ONLY = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [31:0]       wdata,
   input logic              sys_rst,
   input logic [31:0]       count,
   input logic              en1,
   input logic              en2,
   input logic              state_flag,
   input logic              rst_flag
);
   logic svc_wr;
   assign svc_wr = wr_en && (addr[ADDR_W-1:2] == '0) && (wdata[2] || wdata[3]);

   // R2
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !svc_wr |=> count == ($past(count) + 32'd1));

   // R6
   svc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      svc_wr |=> (count == 32'd0));

   // R5
   rst_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst |=> !sys_rst);

   // R5
   rst_flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst |-> rst_flag);

   // R3
   disarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(en1 && en2) |=> !sys_rst);

   // R4
   state_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state_flag) |-> $past(en1 && en2));

   generate
      if (ONCE_ONLY) begin : g_once
         // R8
         enable_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (en1 && en2) |=> (en1 && en2));
      end
   endgenerate
endmodule

bind tbase_wdog tbase_wdog_chk #(
   .ADDR_W   (ADDR_W),
   .ONCE_ONLY(ONCE_ONLY)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .addr      (addr),
   .wdata     (wdata),
   .sys_rst   (sys_rst),
   .count     (tb_count),
   .en1       (en1),
   .en2       (en2),
   .state_flag(state_flag),
   .rst_flag  (rst_flag)
);

// File: tb/tbase_wdog_tb_top.sv
module tbase_wdog_tb_top;
   localparam int          NEXP    = 4;
   localparam logic [31:0] LOWMASK = (32'd1 << NEXP) - 32'd1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  addr = 4'h0;
   logic [31:0] wdata = 32'h0;
   logic [31:0] rd0, rd1;
   logic        irq0, irq1, sr0, sr1;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   typedef struct {
      logic [31:0] cnt;
      bit en1, en2, wds, wrs, rp;
   } ms_t;

   ms_t m0, m1;

   always #10 clk = ~clk;

   tbase_wdog #(.PERIOD_EXP(NEXP), .ADDR_W(4), .ONCE_ONLY(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rd0), .irq(irq0), .sys_rst(sr0));

   tbase_wdog #(.PERIOD_EXP(NEXP), .ADDR_W(4), .ONCE_ONLY(1'b1)) dut_once_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rd1), .irq(irq1), .sys_rst(sr1));

   function automatic ms_t zero_ms();
      ms_t z;
      z.cnt = 32'h0; z.en1 = 0; z.en2 = 0; z.wds = 0; z.wrs = 0; z.rp = 0;
      return z;
   endfunction

   function automatic ms_t step(ms_t s, bit once, bit wr, logic [3:0] a, logic [31:0] d);
      ms_t n = s;
      bit w0 = wr && (a[3:2] == 2'd0);
      bit w1 = wr && (a[3:2] == 2'd1);
      bit keep = w0 && (d[2] || d[3]);
      bit armed = s.en1 && s.en2;
      bit lock = once && armed;
      bit tick = armed && ((s.cnt & LOWMASK) == LOWMASK) && !keep;
      n.cnt = keep ? 32'h0 : s.cnt + 32'd1;
      n.rp  = tick && s.wds;
      if (w0 && d[2]) n.wds = 0; else if (tick) n.wds = 1;
      if (w0 && d[3]) n.wrs = 0; else if (tick && s.wds) n.wrs = 1;
      if (w0) n.en1 = d[1] || lock;
      if (w1) n.en2 = d[0] || lock;
      return n;
   endfunction

   function automatic logic [31:0] rd_exp(ms_t s, logic [3:0] a);
      case (a[3:2])
         2'd0:    return {28'h0, s.wrs, s.wds, s.en1, 1'b0};
         2'd1:    return {31'h0, s.en2};
         2'd2:    return s.cnt;
         default: return 32'h0;
      endcase
   endfunction

   function automatic string rtag(logic [3:0] a);
      case (a[3:2])
         2'd0:    return "R4";
         2'd1:    return "R3";
         2'd2:    return "R2";
         default: return "R9";
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m0 = zero_ms();
         m1 = zero_ms();
      end else begin
         m0 = step(m0, 1'b0, wr_en, addr, wdata);
         m1 = step(m1, 1'b1, wr_en, addr, wdata);
      end
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the reference model
   always @(negedge clk) begin
      if (!done) begin
         chk(rtag(addr), rd0, rd_exp(m0, addr));
         chk("R4 irq", {31'h0, irq0}, {31'h0, m0.wds && m0.en1 && m0.en2});
         chk("R5 sys_rst", {31'h0, sr0}, {31'h0, m0.rp});
         chk("R8 locked rdata", rd1, rd_exp(m1, addr));
         chk("R8 locked irq", {31'h0, irq1}, {31'h0, m1.wds && m1.en1 && m1.en2});
         chk("R8 locked sys_rst", {31'h0, sr1}, {31'h0, m1.rp});
      end
   end

   task automatic do_wr(logic [3:0] a, logic [31:0] d);
      @(posedge clk); #2;
      wr_en = 1'b1; addr = a; wdata = d;
      @(posedge clk); #2;
      wr_en = 1'b0; wdata = 32'h0;
   endtask

   task automatic do_rd(logic [3:0] a);
      @(posedge clk); #2;
      addr = a;
   endtask

   task automatic smp();
      @(negedge clk); #1;
   endtask

   task automatic report();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(20 * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      report();
   end

   initial begin
      logic [31:0] a_v, b_v;
      bit seen;

      // R1: reset state
      repeat (3) @(posedge clk);
      smp();
      chk("R1 word0", rd0, 32'h0);
      chk("R1 irq", {31'h0, irq0}, 32'h0);
      chk("R1 sys_rst", {31'h0, sr0}, 32'h0);
      do_rd(4'h4); smp(); chk("R1 word1", rd0, 32'h0);
      do_rd(4'h8); smp(); chk("R1 timebase", rd0, 32'h0);
      @(posedge clk); #2; rst_n = 1'b1;

      // R2: timebase advances each clock
      smp(); a_v = rd0;
      smp(); b_v = rd0;
      chk("R2 step", b_v, a_v + 32'd1);
      do_wr(4'h8, 32'hDEAD_0000);
      smp(); chk("R2 write ignored", {31'h0, rd0 == 32'hDEAD_0000}, 32'h0);

      // R9: unmapped word and unused bits
      do_rd(4'hC); smp(); chk("R9 unmapped", rd0, 32'h0);
      do_wr(4'h0, 32'hFFFF_FFFF);
      do_rd(4'h0); smp(); chk("R9 unused bits", rd0, 32'h2);

      // R3: one enable only, no expiry
      repeat (40) @(posedge clk);
      smp();
      chk("R3 no flag", {31'h0, rd0[2]}, 32'h0);
      chk("R3 no irq", {31'h0, irq0}, 32'h0);

      // service, then arm
      do_wr(4'h0, 32'h6);
      do_wr(4'h4, 32'h1);
      repeat (18) @(posedge clk);
      do_rd(4'h0); smp();
      chk("R4 flag", {31'h0, rd0[2]}, 32'h1);
      chk("R4 irq", {31'h0, irq0}, 32'h1);

      // R7: zeros to flag bits leave them set
      do_wr(4'h0, 32'h2);
      smp(); chk("R7 flag kept", {31'h0, rd0[2]}, 32'h1);

      // R5: second overflow pulses reset
      seen = 1'b0;
      for (int i = 0; i < 40 && !seen; i++) begin
         smp();
         if (sr0) seen = 1'b1;
      end
      chk("R5 pulse seen", {31'h0, seen}, 32'h1);
      smp();
      chk("R5 pulse one cycle", {31'h0, sr0}, 32'h0);
      chk("R5 flag latched", {31'h0, rd0[3]}, 32'h1);
      repeat (5) @(posedge clk);
      smp(); chk("R5 flag held", {31'h0, rd0[3]}, 32'h1);

      // R6: service clears and restarts
      do_wr(4'h0, 32'hE);
      do_rd(4'h8); smp();
      chk("R6 restart", {31'h0, rd0 <= 32'd3}, 32'h1);
      do_rd(4'h0); smp();
      chk("R6 flags clear", {30'h0, rd0[3:2]}, 32'h0);

      // R6: service on the overflow edge wins
      repeat (20) @(posedge clk);
      smp(); chk("R6 first stage again", {31'h0, rd0[2]}, 32'h1);
      do begin
         @(posedge clk); #2;
      end while ((m0.cnt & LOWMASK) != LOWMASK);
      wr_en = 1'b1; addr = 4'h0; wdata = 32'h6;
      @(posedge clk); #2;
      wr_en = 1'b0; wdata = 32'h0;
      smp();
      chk("R6 coincident no reset", {31'h0, sr0}, 32'h0);
      chk("R6 coincident flag", {31'h0, rd0[2]}, 32'h0);
      smp();
      chk("R6 coincident still quiet", {31'h0, sr0}, 32'h0);

      // R8: disarm attempt
      do_wr(4'h0, 32'h0);
      do_wr(4'h4, 32'h0);
      do_rd(4'h0); smp();
      chk("R8 free en1 cleared", {31'h0, rd0[1]}, 32'h0);
      chk("R8 locked en1 held", {31'h0, rd1[1]}, 32'h1);
      do_rd(4'h4); smp();
      chk("R8 free en2 cleared", rd0, 32'h0);
      chk("R8 locked en2 held", rd1, 32'h1);

      // R3: stopped block stays quiet
      repeat (40) @(posedge clk);
      smp();
      chk("R3 stopped irq", {31'h0, irq0}, 32'h0);
      chk("R3 stopped sys_rst", {31'h0, sr0}, 32'h0);

      report();
   end
endmodule